// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmit Engine

This block turns bytes offered by a transmit FIFO into asynchronous serial frames on a single output line. All timing comes from an input tick at twice the bit rate. One bit period is two ticks. The only exception is the half-length stop period, which lasts one tick. A frame begins only on a tick, and only when the FIFO offers a byte. The byte is taken with a one-cycle pop strobe.

The frame shape is set by configuration inputs:
- a data length of five to eight bits, sent least significant bit first;
- an optional parity bit, even or odd;
- a stop length of one, one and a half, or two bits;
- an idle gap of a programmable number of bit periods after each frame;
- an optional break (line held low) of a programmable number of bit periods, sent after the FIFO has drained.

Configuration is sampled only while the engine is idle, so a frame in progress is never reshaped. The current state is available as a fixed 4-bit code that software can decode. Three single-cycle pulses mark the end of the data, the end of the break and the end of the final idle gap. The output level can be inverted.

Top module: `serial_tx_engine`

## Requirements
- R1: After reset the state code is 0 (idle) and the line is high. A frame starts only on a cycle where `tick2_i` is high and `fifo_valid_i` is high while idle. `fifo_pop_o` is high in exactly that cycle. The start bit is low, shows state 1, and lasts one bit period (two ticks).
- R2: The data length code 0/1/2/3 selects 5/6/7/8 data bits. The bits are sent least significant bit first. Data bit k shows state 2+k and lasts one bit period.
- R3: When parity is enabled, one parity bit follows the data and shows state 10. Select 0 gives even parity: the data bits plus the parity bit hold an even number of ones. Select 1 gives odd parity.
- R4: Stop code 1 (and code 0) sends one high bit in state 11. Code 2 sends state 11, then a high state 12 of one tick (half a bit). Code 3 sends state 11, then a full-bit state 12.
- R5: `done_o` pulses for one cycle at the end of the stop period, but only if the FIFO is empty at that moment. A frame followed by waiting data produces no pulse.
- R6: When break is enabled and the FIFO is empty at the end of the stop period, the line is held low in state 14 for the break count of bit periods. `brk_done_o` then pulses for one cycle. A break count of 0 sends no low period, and the pulse comes at the end of the stop period.
- R7: After every frame the line is held high in state 13 for the gap count of bit periods (none when the count is 0). After the final frame, `idle_done_o` pulses for one cycle as the state returns to 0.
- R8: With the invert input set, `txd_o` is the complement of the normal line level in every state, including idle.
- R9: Configuration inputs are sampled only in the idle state. Changing them during a frame does not alter that frame.
- R10: Between two frames the engine returns to state 0 for one tick before the next start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick2_i | input | 1 | One-cycle strobe at twice the bit rate |
| fifo_valid_i | input | 1 | FIFO holds at least one byte |
| fifo_data_i | input | 8 | Byte at the FIFO head |
| fifo_pop_o | output | 1 | Takes the head byte this cycle |
| cfg_len_i | input | 2 | Data length code (0..3 = 5..8 bits) |
| cfg_par_en_i | input | 1 | Parity bit enable |
| cfg_par_odd_i | input | 1 | Parity select, 1 = odd |
| cfg_stop_i | input | 2 | Stop length code |
| cfg_brk_en_i | input | 1 | Send a break once the FIFO drains |
| cfg_brk_len_i | input | BRK_W | Break length in bit periods |
| cfg_gap_len_i | input | GAP_W | Idle gap in bit periods |
| cfg_inv_i | input | 1 | Invert the serial output |
| txd_o | output | 1 | Serial output |
| state_o | output | 4 | State code |
| done_o | output | 1 | All FIFO data sent |
| brk_done_o | output | 1 | Break finished |
| idle_done_o | output | 1 | Final idle gap finished |

## Verification
The assertions assume three things about the inputs:
- `tick2_i` is a single-cycle strobe with at least one low cycle between strobes;
- `fifo_valid_i` stays high until the byte is popped;
- `fifo_data_i` is steady in the pop cycle.

The stimulus keeps to these assumptions in the following way. It raises the tick on every fourth cycle. It presents the FIFO from a queue that advances only after a pop. It samples the line once between ticks, so every half-bit slot is observed exactly once. Pulse positions are checked against the slot count computed in the bench.

// File: rtl/stx_pkg.sv
// Package: state codes and latched mode bits shared by the transmit engine.
// Assumes: state codes are software-visible and must not be renumbered.
package stx_pkg;

    typedef enum logic [3:0] {
        ST_IDLE  = 4'd0,
        ST_START = 4'd1,
        ST_D0    = 4'd2,
        ST_D1    = 4'd3,
        ST_D2    = 4'd4,
        ST_D3    = 4'd5,
        ST_D4    = 4'd6,
        ST_D5    = 4'd7,
        ST_D6    = 4'd8,
        ST_D7    = 4'd9,
        ST_PAR   = 4'd10,
        ST_STOP1 = 4'd11,
        ST_STOP2 = 4'd12,
        ST_GAP   = 4'd13,
        ST_BRK   = 4'd14
    } stx_state_e;

    typedef struct packed {
        logic [1:0] len;
        logic       par_en;
        logic       par_odd;
        logic [1:0] stop;
        logic       brk_en;
        logic       inv;
    } stx_mode_t;

endpackage

// File: rtl/stx_bit_timer.sv
// Module: half-bit phase and bit-period counter for the transmit engine.
// Does: turns 2x ticks into period ends; counts whole periods inside a state.
// Assumes: leave_i is only asserted together with period_end_o.
module stx_bit_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             active_i,
    input  logic             short_i,
    input  logic             leave_i,
    output logic             period_end_o,
    output logic [CNT_W-1:0] count_o
);

    logic             half_q;
    logic [CNT_W-1:0] cnt_q;

    // A period ends on the second tick, or on the first for a half-bit state.
    assign period_end_o = tick_i & active_i & (half_q | short_i);
    assign count_o      = cnt_q;

    // Track the half-bit phase and the periods spent in the current state.
    always_ff @(posedge clk) begin
        if (!rst_n || !active_i) begin
            half_q <= 1'b0;
            cnt_q  <= '0;
        end else if (period_end_o) begin
            half_q <= 1'b0;
            cnt_q  <= leave_i ? '0 : cnt_q + 1'b1;
        end else if (tick_i) begin
            half_q <= 1'b1;
        end
    end

    // R1: the half phase only ever advances on a tick.
    p_half_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(half_q) |-> $past(tick_i));

    // R6: the period count restarts whenever a state is left.
    p_cnt_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (period_end_o && leave_i) |=> (cnt_q == '0));

endmodule

// File: rtl/stx_line_mux.sv
// Module: selects the serial line level for the current state.
// Does: start/break low, idle/stop/gap high, data bit by state, parity bit.
// Assumes: data bits above the configured length are ignored for parity.
module stx_line_mux
    import stx_pkg::*;
(
    input  stx_state_e state_i,
    input  logic [7:0] data_i,
    input  logic [1:0] len_i,
    input  logic       par_odd_i,
    input  logic       inv_i,
    output logic       txd_o
);

    logic [7:0] keep;
    logic       par_bit;
    logic       raw;

    // Mask off bits beyond the data length and form the parity bit.
    always_comb begin
        for (int i = 0; i < 8; i++) begin
            keep[i] = (i < (32'(len_i) + 5));
        end
        par_bit = (^(data_i & keep)) ^ par_odd_i;
    end

    // Pick the uninverted line level from the state code.
    always_comb begin
        case (state_i)
            ST_IDLE, ST_STOP1, ST_STOP2, ST_GAP: raw = 1'b1;
            ST_START, ST_BRK:                    raw = 1'b0;
            ST_PAR:                              raw = par_bit;
            default:                             raw = data_i[3'(state_i - 4'd2)];
        endcase
    end

    assign txd_o = raw ^ inv_i;

endmodule

// File: rtl/serial_tx_engine.sv
// Module: configurable asynchronous serial transmit engine (top).
// Does: pops bytes, sequences start/data/parity/stop/break/gap states,
//       raises done, break-done and idle-done pulses.
// Assumes: tick2_i is a one-cycle strobe at twice the bit rate; FIFO
//          valid stays high until popped.
module serial_tx_engine
    import stx_pkg::*;
#(
    parameter int BRK_W = 8,
    parameter int GAP_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick2_i,
    input  logic             fifo_valid_i,
    input  logic [7:0]       fifo_data_i,
    output logic             fifo_pop_o,
    input  logic [1:0]       cfg_len_i,
    input  logic             cfg_par_en_i,
    input  logic             cfg_par_odd_i,
    input  logic [1:0]       cfg_stop_i,
    input  logic             cfg_brk_en_i,
    input  logic [BRK_W-1:0] cfg_brk_len_i,
    input  logic [GAP_W-1:0] cfg_gap_len_i,
    input  logic             cfg_inv_i,
    output logic             txd_o,
    output logic [3:0]       state_o,
    output logic             done_o,
    output logic             brk_done_o,
    output logic             idle_done_o
);

    localparam int CNT_W = (BRK_W > GAP_W) ? BRK_W : GAP_W;

    stx_state_e       state_q, state_d;
    stx_mode_t        mode_q;
    logic [BRK_W-1:0] brk_len_q;
    logic [GAP_W-1:0] gap_len_q;
    logic [7:0]       data_q;
    logic             last_q, last_now;
    logic             done_q, brk_q, idle_q;
    logic             done_d, brk_d, idle_d;
    logic             frame_end, to_gap;
    logic             pend, leave;
    logic [CNT_W-1:0] cnt;
    logic             last_data;

    // Take a byte only on a tick while idle.
    assign fifo_pop_o = (state_q == ST_IDLE) && tick2_i && fifo_valid_i;
    assign last_data  = (4'(state_q) == (4'(mode_q.len) + 4'd6));
    assign leave      = pend && (state_d != state_q);

    stx_bit_timer #(.CNT_W(CNT_W)) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick2_i),
        .active_i     (state_q != ST_IDLE),
        .short_i      ((state_q == ST_STOP2) && (mode_q.stop == 2'd2)),
        .leave_i      (leave),
        .period_end_o (pend),
        .count_o      (cnt)
    );

    stx_line_mux u_mux (
        .state_i   (state_q),
        .data_i    (data_q),
        .len_i     (mode_q.len),
        .par_odd_i (mode_q.par_odd),
        .inv_i     (mode_q.inv),
        .txd_o     (txd_o)
    );

    // Next-state and pulse decisions at each period end.
    always_comb begin
        state_d   = state_q;
        frame_end = 1'b0;
        to_gap    = 1'b0;
        done_d    = 1'b0;
        brk_d     = 1'b0;
        idle_d    = 1'b0;
        last_now  = last_q;
        case (state_q)
            ST_IDLE:  if (fifo_pop_o) state_d = ST_START;
            ST_START: if (pend) state_d = ST_D0;
            ST_PAR:   if (pend) state_d = ST_STOP1;
            ST_STOP1: if (pend) begin
                if (mode_q.stop[1]) state_d = ST_STOP2;
                else                frame_end = 1'b1;
            end
            ST_STOP2: if (pend) frame_end = 1'b1;
            ST_BRK: if (pend && (cnt == CNT_W'(brk_len_q) - CNT_W'(1))) begin
                brk_d  = 1'b1;
                to_gap = 1'b1;
            end
            ST_GAP: if (pend && (cnt == CNT_W'(gap_len_q) - CNT_W'(1))) begin
                state_d = ST_IDLE;
                idle_d  = last_q;
            end
            default: if (pend) begin
                if (last_data) state_d = mode_q.par_en ? ST_PAR : ST_STOP1;
                else           state_d = stx_state_e'(state_q + 4'd1);
            end
        endcase
        if (frame_end) begin
            last_now = !fifo_valid_i;
            done_d   = last_now;
            if (last_now && mode_q.brk_en) begin
                if (brk_len_q != '0) begin
                    state_d = ST_BRK;
                end else begin
                    brk_d  = 1'b1;
                    to_gap = 1'b1;
                end
            end else begin
                to_gap = 1'b1;
            end
        end
        if (to_gap) begin
            if (gap_len_q != '0) begin
                state_d = ST_GAP;
            end else begin
                state_d = ST_IDLE;
                idle_d  = last_now;
            end
        end
    end

    // State, pulses, and configuration latched only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            mode_q    <= '0;
            brk_len_q <= '0;
            gap_len_q <= '0;
            data_q    <= '0;
            last_q    <= 1'b0;
            done_q    <= 1'b0;
            brk_q     <= 1'b0;
            idle_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            last_q  <= last_now;
            done_q  <= done_d;
            brk_q   <= brk_d;
            idle_q  <= idle_d;
            if (state_q == ST_IDLE) begin
                mode_q    <= '{len: cfg_len_i, par_en: cfg_par_en_i,
                               par_odd: cfg_par_odd_i, stop: cfg_stop_i,
                               brk_en: cfg_brk_en_i, inv: cfg_inv_i};
                brk_len_q <= cfg_brk_len_i;
                gap_len_q <= cfg_gap_len_i;
            end
            if (fifo_pop_o) data_q <= fifo_data_i;
        end
    end

    assign state_o     = state_q;
    assign done_o      = done_q;
    assign brk_done_o  = brk_q;
    assign idle_done_o = idle_q;

    // R1: a pop always launches a start bit.
    p_pop_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop_o |=> (state_q == ST_START));

    // R1: the start bit drives the line to its active-low level.
    p_start_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 4'd1) |-> (txd_o == mode_q.inv));

    // R4: a half-bit second stop ends on its first tick.
    p_stop_short_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP2 && mode_q.stop == 2'd2 && tick2_i) |=> (state_q != ST_STOP2));

    // R5: done is a single-cycle pulse.
    p_done_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6: break-done follows a break or the end of the stop period.
    p_brk_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        brk_done_o |-> ($past(state_q) == ST_BRK || $past(state_q) == ST_STOP1 ||
                        $past(state_q) == ST_STOP2));

    // R7: idle-done only accompanies the return to idle.
    p_idle_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        idle_done_o |-> (state_q == ST_IDLE));

    // R9: the latched frame shape holds while a frame is running.
    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(mode_q) && $stable(brk_len_q) && $stable(gap_len_q)));

endmodule

// File: tb/sim_serial_tx_engine.sv
`timescale 1ns/1ps
module sim_serial_tx_engine;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick2 = 1'b0;
    logic       fvalid = 1'b0;
    logic [7:0] fdata = '0;
    logic       fpop;
    logic [1:0] c_len = '0;
    logic       c_pen = 1'b0;
    logic       c_podd = 1'b0;
    logic [1:0] c_stop = 2'd1;
    logic       c_ben = 1'b0;
    logic [7:0] c_blen = '0;
    logic [9:0] c_gap = '0;
    logic       c_inv = 1'b0;
    logic       txd;
    logic [3:0] st;
    logic       done, bdone, idone;

    int checks = 0;
    int fails  = 0;

    logic [3:0] exp_st[$];
    logic       exp_tx[$];
    logic [7:0] fifo_q[$];

    always #10 clk = ~clk;

    serial_tx_engine u0 (
        .clk(clk), .rst_n(rst_n), .tick2_i(tick2), .fifo_valid_i(fvalid),
        .fifo_data_i(fdata), .fifo_pop_o(fpop), .cfg_len_i(c_len),
        .cfg_par_en_i(c_pen), .cfg_par_odd_i(c_podd), .cfg_stop_i(c_stop),
        .cfg_brk_en_i(c_ben), .cfg_brk_len_i(c_blen), .cfg_gap_len_i(c_gap),
        .cfg_inv_i(c_inv), .txd_o(txd), .state_o(st), .done_o(done),
        .brk_done_o(bdone), .idle_done_o(idone)
    );

    function automatic string req_of(input logic [3:0] s);
        if (s == 4'd0)       return "R10";
        else if (s == 4'd1)  return "R1";
        else if (s <= 4'd9)  return "R2";
        else if (s == 4'd10) return "R3";
        else if (s <= 4'd12) return "R4";
        else if (s == 4'd13) return "R7";
        else                 return "R6";
    endfunction

    task automatic push(input logic [3:0] s, input logic b, input logic inv, input int n);
        repeat (n) begin
            exp_st.push_back(s);
            exp_tx.push_back(b ^ inv);
        end
    endtask

    task automatic check_int(input string req, input string what, input int act, input int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic run_case(input int len, input int pen, input int podd, input int stop,
                            input int ben, input int blen, input int gap, input int inv,
                            input int nbytes, input int base, input int alter, input string tag);
        int nb, exp_done, exp_brk, exp_idle;
        int idx, cyc, guard, total;
        int n_done, n_brk, n_idle, at_done, at_brk, at_idle;
        logic started, pend;
        exp_st.delete(); exp_tx.delete(); fifo_q.delete();
        nb = len + 5;
        exp_done = -1; exp_brk = -1; exp_idle = -1;
        for (int k = 0; k < nbytes; k++) begin
            logic [7:0] b;
            logic [7:0] mask;
            b = 8'(base + k * 91);
            mask = 8'((1 << nb) - 1);
            fifo_q.push_back(b);
            push(4'd1, 1'b0, 1'(inv), 2);
            for (int i = 0; i < nb; i++) push(4'(2 + i), b[i], 1'(inv), 2);
            if (pen != 0) push(4'd10, (^(b & mask)) ^ 1'(podd), 1'(inv), 2);
            push(4'd11, 1'b1, 1'(inv), 2);
            if (stop == 2) push(4'd12, 1'b1, 1'(inv), 1);
            if (stop == 3) push(4'd12, 1'b1, 1'(inv), 2);
            if (k == nbytes - 1) begin
                exp_done = exp_st.size();
                if (ben != 0) begin
                    push(4'd14, 1'b0, 1'(inv), 2 * blen);
                    exp_brk = exp_st.size();
                end
                push(4'd13, 1'b1, 1'(inv), 2 * gap);
                exp_idle = exp_st.size();
            end else begin
                push(4'd13, 1'b1, 1'(inv), 2 * gap);
                push(4'd0, 1'b1, 1'(inv), 1);
            end
        end
        total = exp_st.size() + 4;
        // reset, then configure while idle
        @(negedge clk);
        rst_n = 1'b0; tick2 = 1'b0; fvalid = 1'b0;
        c_len = 2'(len); c_pen = 1'(pen); c_podd = 1'(podd); c_stop = 2'(stop);
        c_ben = 1'(ben); c_blen = 8'(blen); c_gap = 10'(gap); c_inv = 1'(inv);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idx = 0; cyc = 0; guard = 0; started = 1'b0; pend = 1'b0;
        n_done = 0; n_brk = 0; n_idle = 0; at_done = -1; at_brk = -1; at_idle = -1;
        while (idx < total && guard < 20000) begin
            if (pend) begin
                void'(fifo_q.pop_front());
                pend = 1'b0;
            end
            fvalid = (fifo_q.size() > 0);
            fdata  = (fifo_q.size() > 0) ? fifo_q[0] : 8'h00;
            tick2  = (cyc % 4 == 0);
            if (alter != 0 && idx == 6) begin
                c_len = ~2'(len); c_pen = ~1'(pen); c_stop = 2'd3; c_gap = 10'd5;
            end
            #1;
            if (fpop) pend = 1'b1;
            if (done)  begin n_done++; at_done = idx; end
            if (bdone) begin n_brk++;  at_brk  = idx; end
            if (idone) begin n_idle++; at_idle = idx; end
            if (cyc % 4 == 2) begin
                if (!started && st != 4'd0) started = 1'b1;
                if (started) begin
                    logic [3:0] es;
                    logic       et;
                    es = (idx < exp_st.size()) ? exp_st[idx] : 4'd0;
                    et = (idx < exp_tx.size()) ? exp_tx[idx] : ~1'(inv) ^ 1'b0;
                    if (idx >= exp_tx.size()) et = 1'b1 ^ 1'(inv);
                    checks++;
                    if (st !== es || txd !== et) begin
                        fails++;
                        $display("FAIL %s [%s] slot %0d: state %0d txd %b, expected state %0d txd %b",
                                 req_of(es), tag, idx, st, txd, es, et);
                    end
                    idx++;
                end
            end
            cyc++; guard++;
            @(negedge clk);
        end
        tick2 = 1'b0;
        check_int("R5", {tag, " done pulses"}, n_done, 1);
        check_int("R5", {tag, " done slot"}, at_done, exp_done);
        check_int("R6", {tag, " break-done pulses"}, n_brk, (ben != 0) ? 1 : 0);
        if (ben != 0) check_int("R6", {tag, " break-done slot"}, at_brk, exp_brk);
        check_int("R7", {tag, " idle-done pulses"}, n_idle, 1);
        check_int("R7", {tag, " idle-done slot"}, at_idle, exp_idle);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state, idle line, no pulses, no pop without data
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) begin
            tick2 = ~tick2;
            @(negedge clk);
        end
        tick2 = 1'b0;
        checks++;
        if (st !== 4'd0 || txd !== 1'b1 || done || bdone || idone || fpop) begin
            fails++;
            $display("FAIL R1 reset: state %0d txd %b, expected state 0 txd 1", st, txd);
        end
        // R2 R3 R4: sweep length, parity and stop codes on single bytes
        for (int l = 0; l < 4; l++)
            for (int pe = 0; pe < 2; pe++)
                for (int po = 0; po < 2; po++)
                    for (int sp = 0; sp < 4; sp++)
                        run_case(l, pe, po, sp, 0, 0, 1, 0, 1,
                                 8'h2C + l * 37 + sp * 11 + pe * 5 + po * 3, 0, "sweep R2 R3 R4");
        // R5 R6 R7 R10: three frames, break and gap
        run_case(3, 1, 0, 3, 1, 3, 2, 0, 3, 8'hA7, 0, "multi R10");
        // R8: inverted line, gap 0
        run_case(2, 1, 1, 2, 0, 0, 0, 1, 2, 8'h5E, 0, "invert R8");
        // R6: break enabled with zero length
        run_case(1, 0, 0, 1, 1, 0, 3, 0, 1, 8'h91, 0, "zero break R6");
        // R9: configuration changed mid-frame
        run_case(3, 0, 0, 1, 0, 0, 1, 0, 1, 8'hC3, 1, "cfg hold R9");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule